// File: doc/BRIEF.md
# Receiver Reset Sequencer

This block drives the two reset lines of a serial receiver channel whose clock-data-recovery loop acquires lock on its own. It holds both the analog and the digital reset asserted from power-up. Once the calibration logic reports that it is no longer busy, the block waits a short fixed gap and then releases the analog reset, so that the recovery loop can start tracking the reference clock. The digital reset stays on through the whole acquisition phase. It is released only after the recovery circuit reports frequency lock and that lock has held for a settling time of at least 4 microseconds. At that point a ready flag tells downstream logic that received data may be used.

The settling time is a cycle count computed from the clock frequency, given in kHz, and rounded up. It therefore never falls short of the requested time. If lock drops during settling, the count restarts from zero once lock returns. If lock drops after the channel is ready, the digital reset comes back on and ready drops until lock is re-acquired and has settled again. Both status inputs pass through two-flop synchronizers. The active-low system reset asserts at once and is released in step with the clock.

Top module: `rx_reset_seq`

## Requirements
- R1: During system reset, and afterwards while the busy input stays high, analog reset = 1, digital reset = 1 and ready = 0.
- R2: The busy input passes through a two-flop synchronizer. While busy is high, the analog reset is never released.
- R3: If busy is sampled low at clock edge n and stays low, the analog reset is still 1 after edge n+3 and becomes 0 after edge n+4 (two synchronizer cycles plus a two-cycle gap).
- R4: If busy returns high before the gap ends, the gap is abandoned and the analog reset stays asserted until busy has again been low for a full gap.
- R5: The digital reset is never 0 while the analog reset is 1.
- R6: The settling count is W = ceil(4000 ns × f), with f the clock frequency in GHz (W = 500 at 125 MHz). If lock is sampled high at edge n and stays high, the digital reset is still 1 after edge n+W+1 and becomes 0 after edge n+W+2.
- R7: The ready output is always the inverse of the digital reset, once reset has been released.
- R8: If lock falls during settling, the digital reset stays 1 and the full W-cycle count restarts at the next lock rise, timed as in R6.
- R9: If lock is sampled low at edge n while ready is high, the digital reset returns to 1 and ready to 0 after edge n+2, both unchanged after edge n+1.
- R10: Once released, the analog reset stays 0 until the next system reset, whatever busy and lock do.
- R11: Asserting the system reset at any time drives analog reset = 1, digital reset = 1 and ready = 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset; asserts asynchronously and is released synchronously inside the block |
| cal_busy_i | input | 1 | Calibration busy flag, asynchronous to clk |
| freq_lock_i | input | 1 | Frequency-lock flag from the recovery loop, asynchronous to clk |
| ana_rst_o | output | 1 | Receiver analog reset, active high |
| dig_rst_o | output | 1 | Receiver digital reset, active high |
| rx_ready_o | output | 1 | Receiver ready to accept data |

## Verification
Every result has a fixed latency from the clock edge that samples a stimulus. The analog release comes four edges after busy is sampled low. The digital release comes W+2 edges after lock is sampled high. Lock loss while ready shows up two edges after it is sampled. An asynchronous reset acts immediately, with no edge. The bench drives its inputs at falling edges and records each expected output value in a queue, tagged with the cycle in which it is due. A monitor reads the outputs at falling edges, so each item is compared on the cycle just before a transition and on the cycle it takes effect, and a result that comes one cycle early or late is flagged.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

  typedef enum logic [2:0] {
    ST_HOLD      = 3'd0,
    ST_GAP       = 3'd1,
    ST_LOCK_WAIT = 3'd2,
    ST_SETTLE    = 3'd3,
    ST_READY     = 3'd4
  } seq_state_e;

  // Number of clock cycles covering at least ns_i nanoseconds at freq_khz_i.
  function automatic int unsigned ceil_cycles(longint unsigned freq_khz_i,
                                              longint unsigned ns_i);
    longint unsigned prod;
    prod = freq_khz_i * ns_i;
    return int'((prod + 64'd999999) / 64'd1000000);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rxrst_sync.sv
module rxrst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rxrst_timer.sv
module rxrst_timer #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + WIDTH'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rxrst_fsm.sv
module rxrst_fsm
  import rxrst_pkg::*;
#(
  parameter int unsigned GAP_CYC    = 2,
  parameter int unsigned SETTLE_CYC = 500,
  parameter int unsigned CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_s_i,
  input  logic             lock_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic             ana_rst_o,
  output logic             dig_rst_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       ana_d;
  logic       dig_d;
  logic       rdy_d;
  logic       ana_q;
  logic       dig_q;
  logic       rdy_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD: begin
        if (!busy_s_i) state_d = ST_GAP;
      end
      ST_GAP: begin
        if (busy_s_i)                state_d = ST_HOLD;
        else if (cnt_i == GAP_LAST)  state_d = ST_LOCK_WAIT;
      end
      ST_LOCK_WAIT: begin
        if (lock_s_i) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (!lock_s_i)                  state_d = ST_LOCK_WAIT;
        else if (cnt_i == SETTLE_LAST)  state_d = ST_READY;
      end
      ST_READY: begin
        if (!lock_s_i) state_d = ST_LOCK_WAIT;
      end
      default: state_d = ST_HOLD;
    endcase
  end

  // Timer restarts on every state change and runs only in timed states.
  assign tmr_clr_o = (state_d != state_q);
  assign tmr_en_o  = (state_q == ST_GAP) || (state_q == ST_SETTLE);

  // Output values belonging to the next state, registered.
  always_comb begin
    ana_d = (state_d == ST_HOLD) || (state_d == ST_GAP);
    dig_d = (state_d != ST_READY);
    rdy_d = (state_d == ST_READY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      ana_q   <= 1'b1;
      dig_q   <= 1'b1;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ana_q   <= ana_d;
      dig_q   <= dig_d;
      rdy_q   <= rdy_d;
    end
  end

  assign ana_rst_o = ana_q;
  assign dig_rst_o = dig_q;
  assign ready_o   = rdy_q;

endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq
  import rxrst_pkg::*;
#(
  parameter int unsigned CLK_FREQ_KHZ = 125000,
  parameter int unsigned SETTLE_NS    = 4000,
  parameter int unsigned GAP_CYCLES   = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_busy_i,
  input  logic freq_lock_i,
  output logic ana_rst_o,
  output logic dig_rst_o,
  output logic rx_ready_o
);

  localparam int unsigned SETTLE_CYC = ceil_cycles(CLK_FREQ_KHZ, SETTLE_NS);
  localparam int unsigned MAX_CYC    = max_u(SETTLE_CYC, GAP_CYCLES);
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  logic             rst_int_n;
  logic             busy_s;
  logic             lock_s;
  logic             tmr_clr;
  logic             tmr_en;
  logic [CNT_W-1:0] tmr_cnt;

  // Reset: immediate assertion, release aligned to clk.
  rxrst_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_int_n)
  );

  // Busy resets to the safe "still busy" value.
  rxrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (cal_busy_i),
    .q_o   (busy_s)
  );

  rxrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (freq_lock_i),
    .q_o   (lock_s)
  );

  rxrst_timer #(.WIDTH(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .cnt_o (tmr_cnt)
  );

  rxrst_fsm #(
    .GAP_CYC    (GAP_CYCLES),
    .SETTLE_CYC (SETTLE_CYC),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .busy_s_i  (busy_s),
    .lock_s_i  (lock_s),
    .cnt_i     (tmr_cnt),
    .tmr_clr_o (tmr_clr),
    .tmr_en_o  (tmr_en),
    .ana_rst_o (ana_rst_o),
    .dig_rst_o (dig_rst_o),
    .ready_o   (rx_ready_o)
  );

endmodule

// File: rtl/rx_reset_seq_chk.sv
module rx_reset_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cal_busy_i,
  input logic freq_lock_i,
  input logic ana_rst_o,
  input logic dig_rst_o,
  input logic rx_ready_o
);

  // R5: digital side never leaves reset ahead of analog side
  a_r5_dig_after_ana: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_rst_o |-> !ana_rst_o);

  // R10: analog release is sticky until system reset
  a_r10_ana_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_rst_o |=> !ana_rst_o);

  // R7: ready mirrors the digital reset
  a_r7_ready_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready_o == !dig_rst_o);

  // R3: analog release only after busy was low through the gap
  a_r3_busy_low_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ana_rst_o) |-> (!$past(cal_busy_i, 2) && !$past(cal_busy_i, 3) && !$past(cal_busy_i, 4)));

  // R9: ready only while lock has been present through the synchronizer
  a_r9_ready_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready_o |-> $past(freq_lock_i, 3));

endmodule

bind rx_reset_seq rx_reset_seq_chk u_chk (.*);

// File: tb/test_rx_reset_seq.sv
module test_rx_reset_seq;

  localparam int W = 500; // 4 us at 125 MHz

  logic clk;
  logic rst_n;
  logic cal_busy_i;
  logic freq_lock_i;
  logic ana_rst_o;
  logic dig_rst_o;
  logic rx_ready_o;

  int checks;
  int errors;
  int cyc;

  typedef struct {
    int         due;
    logic [2:0] exp;  // {analog, digital, ready}
    string      tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  exp_item_t cur;

  rx_reset_seq i_rx_reset_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cal_busy_i  (cal_busy_i),
    .freq_lock_i (freq_lock_i),
    .ana_rst_o   (ana_rst_o),
    .dig_rst_o   (dig_rst_o),
    .rx_ready_o  (rx_ready_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual {ana,dig,rdy}=%b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Driver side: schedule an expected output triple dc cycles from now.
  task automatic expect_in(input int dc, input logic [2:0] e, input string tag);
    exp_item_t it;
    it.due = cyc + dc;
    it.exp = e;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      cur = exp_q.pop_front();
      check({ana_rst_o, dig_rst_o, rx_ready_o} === cur.exp, cur.tag,
            {ana_rst_o, dig_rst_o, rx_ready_o}, cur.exp);
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual run still active expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    cyc = 0;
    rst_n = 1'b0;
    cal_busy_i = 1'b1;
    freq_lock_i = 1'b0;
    idle(3);
    check({ana_rst_o, dig_rst_o, rx_ready_o} === 3'b110, "R1 in reset",
          {ana_rst_o, dig_rst_o, rx_ready_o}, 3'b110);
    rst_n = 1'b1;
    expect_in(4,  3'b110, "R1 busy high after reset");
    expect_in(10, 3'b110, "R2 busy still high");
    drain();

    // R4: short busy-low glitch does not finish the gap
    @(negedge clk);
    cal_busy_i = 1'b0;
    @(negedge clk);
    cal_busy_i = 1'b1;
    expect_in(5, 3'b110, "R4 gap aborted");
    expect_in(9, 3'b110, "R4 gap aborted late");
    drain();

    // R3: steady busy low
    @(negedge clk);
    cal_busy_i = 1'b0;
    expect_in(4, 3'b110, "R3 before analog release");
    expect_in(5, 3'b010, "R3 analog released");
    drain();

    // R10: busy activity after release is ignored
    cal_busy_i = 1'b1;
    expect_in(6, 3'b010, "R10 busy high ignored");
    idle(2);
    cal_busy_i = 1'b0;
    drain();

    // R6/R8: lock, drop during settling, lock again
    @(negedge clk);
    freq_lock_i = 1'b1;
    expect_in(10, 3'b010, "R5 digital held while settling");
    expect_in(100, 3'b010, "R8 digital held before drop");
    idle(100);
    freq_lock_i = 1'b0;
    idle(10);
    freq_lock_i = 1'b1;
    expect_in(W - 110 + 3, 3'b010, "R8 no release at first-lock deadline");
    expect_in(W + 2, 3'b010, "R6 still settling");
    expect_in(W + 3, 3'b001, "R6 digital released");
    expect_in(W + 4, 3'b001, "R7 ready high");
    drain();

    // R9: lock lost while ready
    idle(5);
    freq_lock_i = 1'b0;
    expect_in(2, 3'b001, "R9 still ready one edge later");
    expect_in(3, 3'b010, "R9 digital reasserted");
    expect_in(8, 3'b010, "R10 analog stays released");
    drain();

    // Re-lock with no interruption
    @(negedge clk);
    freq_lock_i = 1'b1;
    expect_in(W + 2, 3'b010, "R6 relock still settling");
    expect_in(W + 3, 3'b001, "R6 relock released");
    drain();

    // R11: asynchronous reset mid-operation
    idle(3);
    #1 rst_n = 1'b0;
    #1;
    check({ana_rst_o, dig_rst_o, rx_ready_o} === 3'b110, "R11 immediate reset",
          {ana_rst_o, dig_rst_o, rx_ready_o}, 3'b110);
    cal_busy_i = 1'b1;
    idle(2);
    rst_n = 1'b1;
    expect_in(6, 3'b110, "R1 after second reset");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule